// File: doc/BRIEF.md
# Target Address and Common-Command Engine

This block is the byte-level decision logic of a target on a two-wire serial bus with dynamic addressing. A bus front end, not part of this block, reports bus events as one-cycle strobes: a start or restart carrying a 7-bit address and a direction bit, a written byte, a request for a read byte, a controller NACK and a STOP. It also raises a flag while the current transfer is a common command. The engine answers each start, write and read with a registered acknowledge and, for reads, a data byte. It keeps the target's dynamic address and carries out the common commands that assign, copy, clear and report identity.

Its static address, 48-bit provisioned ID and the two characteristic bytes are parameters. The dynamic address leaves reset at zero, which means that none has been assigned. Every response appears on the output registers one clock after the event that caused it.

Top module: `tac_engine`

## Requirements
- R1: After reset the dynamic address reads 0 and no response strobe is raised.
- R2: A start, write or read event produces exactly one response strobe one cycle later. A start is acknowledged when the address equals the dynamic address if that is nonzero, and the static address otherwise; the static address is ignored once a dynamic address is held.
- R3: Outside address-assignment mode, a start to the broadcast address 0x7E is always acknowledged. Such a start also ends any command in progress, so the next command byte is latched afresh.
- R4: While address-assignment mode (command 0x07) is active, only a broadcast start can be acknowledged, and only while the dynamic address is 0. The mode stays active across restarts until STOP.
- R5: In assignment mode, read bytes come out as the six ID bytes least significant first, then the bus-characteristic byte, then the device-characteristic byte. A byte offset advances per byte. A controller NACK leaves the offset and all other state unchanged, so reading resumes where it stopped.
- R6: In assignment mode, the byte written once the offset has reached 8 becomes the dynamic address (bits 6:0), and the command state and offset clear.
- R7: Command codes 0x87 (direct) and 0x29 (broadcast) copy the static address into the dynamic address. Code 0x06 sets it to 0.
- R8: For code 0x88, the first data byte after the command byte becomes the dynamic address. The command byte itself does not change the address.
- R9: Code 0x8D returns ID bytes from the current offset, least significant first. Codes 0x8E and 0x8F return the bus-characteristic or device-characteristic byte on every read without advancing.
- R10: STOP clears the latched command, the in-command flag, the offset and assignment mode.
- R11: The first byte written while the command flag is high and no command is held is latched as the command code and consumed.
- R12: A write after a read-direction start, a read after a write-direction start, and any write or read while not selected are NACKed. Any read that is NACKed, or that falls outside a command that supplies data, returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event strobe, one cycle per event |
| ev_kind | input | 3 | 0 start, 1 write byte, 2 read request, 3 NACK, 4 STOP |
| ev_data | input | 8 | Start: {address[6:0], read bit}; write: data byte |
| ccc_mode | input | 1 | High while the transfer is a common command |
| resp_vld | output | 1 | Response strobe for start, write and read events |
| resp_ack | output | 1 | 1 = acknowledge, 0 = NACK |
| rd_data | output | 8 | Read byte, 0xFF when nothing is supplied |
| dyn_addr | output | 7 | Current dynamic address, 0 when unassigned |

## Verification
A corrupted byte offset shows at the next read as the wrong identity byte, or as a misplaced address capture at the end of assignment. A stale assignment-mode or in-command flag shows at the very next broadcast start, as a wrong ACK or a command byte that is not latched. A wrong dynamic address shows on `dyn_addr` one cycle after the write that set it and in every later address match. Every such fault therefore reaches the ports within one or two events of the sequence that exposes it.

// File: rtl/tac_pkg.sv
package tac_pkg;
    localparam int ADDR_W = 7;
    localparam int OFF_W  = 4;
    localparam int ID_BYTES = 6;

    localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E;

    localparam logic [7:0] CMD_ASSIGN   = 8'h07;
    localparam logic [7:0] CMD_CLEAR    = 8'h06;
    localparam logic [7:0] CMD_ALLSTAT  = 8'h29;
    localparam logic [7:0] CMD_DIRSTAT  = 8'h87;
    localparam logic [7:0] CMD_NEWADDR  = 8'h88;
    localparam logic [7:0] CMD_GETID    = 8'h8D;
    localparam logic [7:0] CMD_GETBCHAR = 8'h8E;
    localparam logic [7:0] CMD_GETDCHAR = 8'h8F;

    typedef enum logic [2:0] {
        EV_START = 3'd0,
        EV_WRITE = 3'd1,
        EV_READ  = 3'd2,
        EV_NACK  = 3'd3,
        EV_STOP  = 3'd4
    } ev_kind_e;

    typedef struct packed {
        logic              sel;
        logic              rd_dir;
        logic              assign_mode;
        logic              in_cmd;
        logic [7:0]        cmd;
        logic [OFF_W-1:0]  off;
        logic [ADDR_W-1:0] dyn;
        logic              vld;
        logic              ack;
        logic [7:0]        rdata;
    } tac_state_t;
endpackage

// File: rtl/tac_match.sv
module tac_match
    import tac_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] dyn_i,
    input  logic [ADDR_W-1:0] stat_i,
    input  logic              assign_i,
    output logic              bcast_o,
    output logic              hit_o
);
    logic [ADDR_W-1:0] own_addr;

    always_comb begin
        bcast_o  = (addr_i == BCAST_ADDR);
        own_addr = (dyn_i != '0) ? dyn_i : stat_i;
        if (assign_i) begin
            hit_o = bcast_o && (dyn_i == '0);
        end else begin
            hit_o = bcast_o || (addr_i == own_addr);
        end
    end
endmodule

// File: rtl/tac_rdmux.sv
module tac_rdmux
    import tac_pkg::*;
#(
    parameter logic [8*ID_BYTES-1:0] ID_VAL = '0
) (
    input  logic [7:0]       cmd_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [7:0]       bchar_i,
    input  logic [7:0]       dchar_i,
    output logic [7:0]       byte_o,
    output logic             adv_o
);
    logic [7:0] id_byte;
    logic       id_ok;

    always_comb begin
        id_byte = 8'hFF;
        id_ok   = 1'b0;
        for (int i = 0; i < ID_BYTES; i++) begin
            if (off_i == OFF_W'(i)) begin
                id_byte = ID_VAL[i*8 +: 8];
                id_ok   = 1'b1;
            end
        end
    end

    always_comb begin
        byte_o = 8'hFF;
        adv_o  = 1'b0;
        unique case (cmd_i)
            CMD_ASSIGN: begin
                if (id_ok) begin
                    byte_o = id_byte;
                    adv_o  = 1'b1;
                end else if (off_i == OFF_W'(ID_BYTES)) begin
                    byte_o = bchar_i;
                    adv_o  = 1'b1;
                end else if (off_i == OFF_W'(ID_BYTES + 1)) begin
                    byte_o = dchar_i;
                    adv_o  = 1'b1;
                end
            end
            CMD_GETID: begin
                if (id_ok) begin
                    byte_o = id_byte;
                    adv_o  = 1'b1;
                end
            end
            CMD_GETBCHAR: byte_o = bchar_i;
            CMD_GETDCHAR: byte_o = dchar_i;
            default: ;
        endcase
    end
endmodule

// File: rtl/tac_engine.sv
module tac_engine
    import tac_pkg::*;
#(
    parameter logic [ADDR_W-1:0]     STATIC_ADDR = 7'h3A,
    parameter logic [8*ID_BYTES-1:0] ID_VAL      = 48'h0123_4567_89AB,
    parameter logic [7:0]            BCHAR       = 8'h26,
    parameter logic [7:0]            DCHAR       = 8'hC4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [2:0]        ev_kind,
    input  logic [7:0]        ev_data,
    input  logic              ccc_mode,
    output logic              resp_vld,
    output logic              resp_ack,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] dyn_addr
);
    localparam int ASSIGN_LAST = ID_BYTES + 2;

    tac_state_t s_d, s_q;
    ev_kind_e   kind;
    logic       is_bcast, addr_hit;
    logic [7:0] rd_byte;
    logic       rd_adv;
    logic [7:0] cmd_now;
    logic       cmd_byte;

    assign kind = ev_kind_e'(ev_kind);

    tac_match u_match (
        .addr_i   (ev_data[7:1]),
        .dyn_i    (s_q.dyn),
        .stat_i   (STATIC_ADDR),
        .assign_i (s_q.assign_mode),
        .bcast_o  (is_bcast),
        .hit_o    (addr_hit)
    );

    tac_rdmux #(.ID_VAL(ID_VAL)) u_rdmux (
        .cmd_i   (s_q.cmd),
        .off_i   (s_q.off),
        .bchar_i (BCHAR),
        .dchar_i (DCHAR),
        .byte_o  (rd_byte),
        .adv_o   (rd_adv)
    );

    always_comb begin
        s_d       = s_q;
        s_d.vld   = 1'b0;
        s_d.ack   = 1'b0;
        s_d.rdata = 8'hFF;
        cmd_now   = s_q.cmd;
        cmd_byte  = 1'b0;
        if (ev_valid) begin
            unique case (kind)
                EV_START: begin
                    s_d.vld    = 1'b1;
                    s_d.rd_dir = ev_data[0];
                    s_d.sel    = addr_hit;
                    s_d.ack    = addr_hit;
                    if (is_bcast && !s_q.assign_mode) begin
                        s_d.in_cmd = 1'b0;
                        s_d.cmd    = 8'h00;
                        s_d.off    = '0;
                    end
                end
                EV_WRITE: begin
                    s_d.vld = 1'b1;
                    s_d.ack = s_q.sel && !s_q.rd_dir;
                    if (s_d.ack && ccc_mode) begin
                        if (!s_q.in_cmd) begin
                            cmd_now    = ev_data;
                            cmd_byte   = 1'b1;
                            s_d.cmd    = ev_data;
                            s_d.in_cmd = 1'b1;
                            if (ev_data == CMD_ASSIGN) s_d.assign_mode = 1'b1;
                        end
                        unique case (cmd_now)
                            CMD_ASSIGN: begin
                                if (s_q.off == OFF_W'(ASSIGN_LAST)) begin
                                    s_d.dyn    = ev_data[ADDR_W-1:0];
                                    s_d.in_cmd = 1'b0;
                                    s_d.cmd    = 8'h00;
                                    s_d.off    = '0;
                                end
                            end
                            CMD_DIRSTAT, CMD_ALLSTAT: s_d.dyn = STATIC_ADDR;
                            CMD_CLEAR:                s_d.dyn = '0;
                            CMD_NEWADDR: begin
                                if (!cmd_byte) s_d.dyn = ev_data[ADDR_W-1:0];
                            end
                            default: ;
                        endcase
                    end
                end
                EV_READ: begin
                    s_d.vld = 1'b1;
                    s_d.ack = s_q.sel && s_q.rd_dir;
                    if (s_d.ack && ccc_mode && s_q.in_cmd) begin
                        s_d.rdata = rd_byte;
                        if (rd_adv) s_d.off = s_q.off + 1'b1;
                    end
                end
                EV_STOP: begin
                    s_d.sel         = 1'b0;
                    s_d.rd_dir      = 1'b0;
                    s_d.assign_mode = 1'b0;
                    s_d.in_cmd      = 1'b0;
                    s_d.cmd         = 8'h00;
                    s_d.off         = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.rdata <= 8'hFF;
        end else begin
            s_q <= s_d;
        end
    end

    assign resp_vld = s_q.vld;
    assign resp_ack = s_q.ack;
    assign rd_data  = s_q.rdata;
    assign dyn_addr = s_q.dyn;

    // R1 R6 R7 R8: only a write event may move the dynamic address
    dyn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_valid && ev_kind == EV_WRITE) |=> $stable(dyn_addr));

    // R10
    stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EV_STOP) |=>
            (s_q.off == '0 && !s_q.in_cmd && !s_q.assign_mode && s_q.cmd == 8'h00));

    // R2
    resp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |-> $past(ev_valid && ev_kind != EV_STOP && ev_kind != EV_NACK));

    // R12
    nack_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && !resp_ack) |-> (rd_data == 8'hFF));

    // R5
    off_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.off <= OFF_W'(ASSIGN_LAST));

    // R4
    assign_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_ack && s_q.assign_mode && $past(ev_valid && ev_kind == EV_START))
            |-> (dyn_addr == '0));
endmodule

// File: tb/tb_tac_engine.sv
module tb_tac_engine;
    typedef struct packed {
        logic [2:0] kind;
        logic [7:0] dat;
        logic       ccc;
        logic       eack;
        logic [7:0] erd;
        logic [6:0] edyn;
    } vec_t;

    function automatic vec_t S(input logic [6:0] a, input logic rd, input logic ea, input logic [6:0] ed);
        return '{kind: 3'd0, dat: {a, rd}, ccc: 1'b0, eack: ea, erd: 8'hFF, edyn: ed};
    endfunction
    function automatic vec_t W(input logic [7:0] d, input logic c, input logic ea, input logic [6:0] ed);
        return '{kind: 3'd1, dat: d, ccc: c, eack: ea, erd: 8'hFF, edyn: ed};
    endfunction
    function automatic vec_t R(input logic c, input logic ea, input logic [7:0] er, input logic [6:0] ed);
        return '{kind: 3'd2, dat: 8'h00, ccc: c, eack: ea, erd: er, edyn: ed};
    endfunction
    function automatic vec_t N(input logic [6:0] ed);
        return '{kind: 3'd3, dat: 8'h00, ccc: 1'b0, eack: 1'b0, erd: 8'hFF, edyn: ed};
    endfunction
    function automatic vec_t P(input logic [6:0] ed);
        return '{kind: 3'd4, dat: 8'h00, ccc: 1'b0, eack: 1'b0, erd: 8'hFF, edyn: ed};
    endfunction

    localparam int NV = 55;
    localparam vec_t VECS [NV] = '{
        S(7'h3A,0,1,7'h00), W(8'h55,0,1,7'h00), P(7'h00), S(7'h22,0,0,7'h00),
        S(7'h7E,0,1,7'h00), W(8'h07,1,1,7'h00), S(7'h7E,1,1,7'h00),
        R(1,1,8'hAB,7'h00), R(1,1,8'h89,7'h00), R(1,1,8'h67,7'h00), N(7'h00),
        R(1,1,8'h45,7'h00), R(1,1,8'h23,7'h00), R(1,1,8'h01,7'h00),
        R(1,1,8'h26,7'h00), R(1,1,8'hC4,7'h00),
        S(7'h7E,0,1,7'h00), W(8'h30,1,1,7'h30), S(7'h7E,1,0,7'h30), S(7'h30,0,0,7'h30), P(7'h30),
        S(7'h3A,0,0,7'h30), S(7'h30,1,1,7'h30), R(0,1,8'hFF,7'h30), P(7'h30),
        S(7'h7E,0,1,7'h30), W(8'h06,1,1,7'h00), P(7'h00), S(7'h30,0,0,7'h00), S(7'h3A,0,1,7'h00), P(7'h00),
        S(7'h7E,0,1,7'h00), W(8'h29,1,1,7'h3A), P(7'h3A),
        S(7'h7E,0,1,7'h3A), W(8'h88,1,1,7'h3A), S(7'h3A,0,1,7'h3A), W(8'h45,1,1,7'h45), P(7'h45),
        S(7'h7E,0,1,7'h45), W(8'h8D,1,1,7'h45), S(7'h45,1,1,7'h45),
        R(1,1,8'hAB,7'h45), R(1,1,8'h89,7'h45), P(7'h45),
        S(7'h7E,0,1,7'h45), W(8'h8E,1,1,7'h45), S(7'h45,1,1,7'h45),
        R(1,1,8'h26,7'h45), R(1,1,8'h26,7'h45),
        S(7'h7E,0,1,7'h45), W(8'h8F,1,1,7'h45), S(7'h45,1,1,7'h45), R(1,1,8'hC4,7'h45), P(7'h45)
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [2:0] ev_kind = 3'd0;
    logic [7:0] ev_data = 8'h00;
    logic       ccc_mode = 1'b0;
    logic       resp_vld, resp_ack;
    logic [7:0] rd_data;
    logic [6:0] dyn_addr;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    tac_engine dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_data(ev_data), .ccc_mode(ccc_mode), .resp_vld(resp_vld),
        .resp_ack(resp_ack), .rd_data(rd_data), .dyn_addr(dyn_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        string tag;
        @(negedge clk);
        ev_valid = 1'b1;
        ev_kind  = v.kind;
        ev_data  = v.dat;
        ccc_mode = v.ccc;
        @(negedge clk);
        ev_valid = 1'b0;
        case (v.kind)
            3'd0: tag = $sformatf("R2 R3 R4 start #%0d", idx);
            3'd1: tag = $sformatf("R6 R7 R8 R11 R12 write #%0d", idx);
            3'd2: tag = $sformatf("R5 R9 R12 read #%0d", idx);
            default: tag = $sformatf("R5 R10 nack/stop #%0d", idx);
        endcase
        if (v.kind <= 3'd2) begin
            chk({tag, " vld"}, 32'(resp_vld), 32'd1);
            chk({tag, " ack"}, 32'(resp_ack), 32'(v.eack));
            if (v.kind == 3'd2) chk({tag, " data"}, 32'(rd_data), 32'(v.erd));
        end else begin
            chk({tag, " vld"}, 32'(resp_vld), 32'd0);
        end
        chk({tag, " dyn"}, 32'(dyn_addr), 32'(v.edyn));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset dyn", 32'(dyn_addr), 32'h0);
        chk("R1 reset vld", 32'(resp_vld), 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R12 direction mismatch
        run_vec(S(7'h45,1,1,7'h45), 100);
        run_vec(W(8'h12,0,0,7'h45), 101);
        run_vec(P(7'h45), 102);
        run_vec(S(7'h45,0,1,7'h45), 103);
        run_vec(R(0,0,8'hFF,7'h45), 104);
        run_vec(P(7'h45), 105);

        // R10: partial assignment read, STOP, then offset restarts at 0
        run_vec(S(7'h7E,0,1,7'h45), 110);
        run_vec(W(8'h06,1,1,7'h00), 111);
        run_vec(P(7'h00), 112);
        run_vec(S(7'h7E,0,1,7'h00), 113);
        run_vec(W(8'h07,1,1,7'h00), 114);
        run_vec(S(7'h7E,1,1,7'h00), 115);
        run_vec(R(1,1,8'hAB,7'h00), 116);
        run_vec(R(1,1,8'h89,7'h00), 117);
        run_vec(P(7'h00), 118);
        // R7 direct static copy code on broadcast
        run_vec(S(7'h7E,0,1,7'h00), 119);
        run_vec(W(8'h87,1,1,7'h3A), 120);
        run_vec(P(7'h3A), 121);
        // R9 identity read starts at offset 0 again
        run_vec(S(7'h7E,0,1,7'h3A), 122);
        run_vec(W(8'h8D,1,1,7'h3A), 123);
        run_vec(S(7'h3A,1,1,7'h3A), 124);
        run_vec(R(1,1,8'hAB,7'h3A), 125);
        run_vec(P(7'h3A), 126);

        // R1 reset in mid-run clears the dynamic address
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset dyn", 32'(dyn_addr), 32'h0);
        chk("R1 mid reset vld", 32'(resp_vld), 32'h0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule